// File: doc/BRIEF.md
# Reversible-Cell Unsigned Array Multiplier

This block multiplies two unsigned operands, 4 bits each by default, and returns the full double-width product. It is purely combinational. It is built only from leaf cells that each model a reversible gate, meaning the cell maps its inputs to its outputs one-to-one. The block is meant as a structural reference for flows that map onto reversible logic, and it also serves as an ordinary multiplier whose netlist contains only two kinds of cells.

Two cell types are used. The first is a three-line Peres cell, which computes (x, y, z) -> (x, x^y, (x&y)^z). The second is a four-line full-adder cell made of two cascaded Peres cells. The block has three stages. First, a grid of Peres cells forms every AND term of the two operands. Second, a carry-save array reduces the shifted partial-product rows down to one sum vector and one carry vector. Third, a ripple carry-propagate row adds those two vectors to form the upper half of the product. Every ancilla input is tied to 0. Every cell output that feeds no other cell and is not a product bit is collected on a garbage bus. No cell output drives more than one consumer.

With the default width, the block contains 16 Peres cells that form the AND terms, 4 Peres cells used as half adders and 8 full-adder cells, for 28 cells in all, with 28 constant-0 inputs. The garbage bus is 40 bits wide.

Top module: `rev_array_mult`

## Requirements
- R1: `prod` equals the unsigned product of `opa` and `opb` for every one of the 256 operand pairs.
- R2: When either operand is zero, `prod` is zero.
- R3: When both operands are all ones, `prod` is 225. Its top bit is set, and that bit is driven by the last carry of the ripple row.
- R4: The Peres cell maps (x, y, z) to (x, x^y, (x&y)^z), and its 8 input patterns give 8 distinct output patterns.
- R5: The full-adder cell maps (x, y, z, w) to (x, x^y, x^y^z, ((x^y)&z)^(x&y)^w). With w = 0 the last output is the majority of x, y and z. Its 16 input patterns give 16 distinct output patterns.
- R6: Garbage bits [OPW-1:0] carry operand `opb` out of the partial-product grid. Bit i equals `opb[i]`, because `opb[i]` travels along row i through the pass-through output of every cell in that row.
- R7: Garbage bits [OPW+OPW*OPW-1:OPW] hold the middle Peres output of each partial-product cell. The bit at offset OPW + i*OPW + j equals `opa[j] ^ opb[i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | OPW (4) | Multiplicand, unsigned |
| opb | input | OPW (4) | Multiplier, unsigned |
| prod | output | 2*OPW (8) | Unsigned product |
| garbage | output | OPW*OPW + 2*OPW + 2*OPW*(OPW-2) (40) | Unconsumed cell outputs: row pass-through, then grid XOR lines, then half-adder pass lines, then full-adder pass lines |

## Verification
The product is checked for every pair of operands. This separates faults that only show up at particular carry chains: a broken ripple cell shows up only for large operands, while a swapped partial-product term shows up only when the two operands differ. The zero pairs and the all-ones pair are named separately, because they isolate a stuck carry and the final carry out. Each leaf cell is also driven through all of its input patterns, to confirm its mapping and that no two inputs give the same output. The garbage lines from the grid are compared too, which shows whether the operands are routed to the right rows and columns.

// File: rtl/rev_mult_pkg.sv
package rev_mult_pkg;

  // Peres mapping, packed as {r, q, p}
  function automatic logic [2:0] peres_map(input logic x, input logic y, input logic z);
    return {(x & y) ^ z, x ^ y, x};
  endfunction

  // Two cascaded Peres mappings, packed as {carry, sum, q, p}
  function automatic logic [3:0] pfa_map(input logic x, input logic y, input logic z,
                                         input logic w);
    logic [2:0] s1;
    logic [2:0] s2;
    s1 = peres_map(x, y, w);
    s2 = peres_map(s1[1], z, s1[2]);
    return {s2[2], s2[1], s2[0], s1[0]};
  endfunction

  function automatic int unsigned fa_count(input int unsigned n);
    return n * (n - 2);
  endfunction

  function automatic int unsigned ha_count(input int unsigned n);
    return n;
  endfunction

  function automatic int unsigned garbage_width(input int unsigned n);
    return n * n + n + ha_count(n) + 2 * fa_count(n);
  endfunction

  function automatic int unsigned ancilla_count(input int unsigned n);
    return n * n + ha_count(n) + fa_count(n);
  endfunction

endpackage

// File: rtl/rv_peres.sv
module rv_peres
  import rev_mult_pkg::*;
(
  input  logic x,
  input  logic y,
  input  logic z,
  output logic p,
  output logic q,
  output logic r
);

  assign {r, q, p} = peres_map(x, y, z);

endmodule

// File: rtl/rv_peres_fa.sv
module rv_peres_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  input  logic w,
  output logic p,
  output logic q,
  output logic s,
  output logic co
);

  logic mid_q;
  logic mid_r;

  // first stage: x passes, x^y, (x&y)^w
  rv_peres u_first (
    .x(x), .y(y), .z(w),
    .p(p), .q(mid_q), .r(mid_r)
  );

  // second stage folds z into the xor line and the carry line
  rv_peres u_second (
    .x(mid_q), .y(z), .z(mid_r),
    .p(q), .q(s), .r(co)
  );

endmodule

// File: rtl/rv_ppgen.sv
module rv_ppgen #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [N*N-1:0] pp,
  output logic [N-1:0]   gb_pass,
  output logic [N*N-1:0] gb_xor
);

  // row line: b[i] enters at column 0 and leaves on the last pass output
  logic [N-1:0][N:0] row_line;

  for (genvar i = 0; i < N; i++) begin : g_row
    assign row_line[i][0] = b[i];
    assign gb_pass[i]     = row_line[i][N];
    for (genvar j = 0; j < N; j++) begin : g_col
      rv_peres u_cell (
        .x(row_line[i][j]),
        .y(a[j]),
        .z(1'b0),
        .p(row_line[i][j+1]),
        .q(gb_xor[i*N+j]),
        .r(pp[i*N+j])
      );
    end
  end

endmodule

// File: rtl/rv_csa_array.sv
module rv_csa_array
  import rev_mult_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [N*N-1:0]               pp,
  output logic [2*N-1:0]               prod,
  output logic [ha_count(N)-1:0]       gb_ha,
  output logic [2*fa_count(N)-1:0]     gb_fa
);

  localparam int unsigned ROW_FA = (N - 2) * (N - 1);

  // carry-save rows 1..N-1: sum vector (N bits) and carry vector (N-1 bits)
  logic [N-1:1][N-1:0] sum_row;
  logic [N-1:1][N-2:0] car_row;
  logic [N-2:0]        rip_c;

  assign prod[0] = pp[0];

  // row 1: half adders merge row 0 (shifted down one place) with row 1
  for (genvar j = 0; j < N - 1; j++) begin : g_row1
    rv_peres u_ha (
      .x(pp[j+1]),
      .y(pp[N+j]),
      .z(1'b0),
      .p(gb_ha[j]),
      .q(sum_row[1][j]),
      .r(car_row[1][j])
    );
  end
  assign sum_row[1][N-1] = pp[N+N-1];
  assign prod[1]         = sum_row[1][0];

  // rows 2..N-1: full adders fold in the next partial-product row
  for (genvar i = 2; i < N; i++) begin : g_rows
    for (genvar j = 0; j < N - 1; j++) begin : g_fa
      localparam int unsigned K = (i - 2) * (N - 1) + j;
      rv_peres_fa u_fa (
        .x(pp[i*N+j]),
        .y(sum_row[i-1][j+1]),
        .z(car_row[i-1][j]),
        .w(1'b0),
        .p(gb_fa[2*K]),
        .q(gb_fa[2*K+1]),
        .s(sum_row[i][j]),
        .co(car_row[i][j])
      );
    end
    assign sum_row[i][N-1] = pp[i*N+N-1];
    assign prod[i]         = sum_row[i][0];
  end

  // carry-propagate row
  rv_peres u_rip_ha (
    .x(sum_row[N-1][1]),
    .y(car_row[N-1][0]),
    .z(1'b0),
    .p(gb_ha[N-1]),
    .q(prod[N]),
    .r(rip_c[0])
  );

  for (genvar j = 1; j < N - 1; j++) begin : g_rip
    localparam int unsigned K = ROW_FA + j - 1;
    rv_peres_fa u_fa (
      .x(sum_row[N-1][j+1]),
      .y(car_row[N-1][j]),
      .z(rip_c[j-1]),
      .w(1'b0),
      .p(gb_fa[2*K]),
      .q(gb_fa[2*K+1]),
      .s(prod[N+j]),
      .co(rip_c[j])
    );
  end

  assign prod[2*N-1] = rip_c[N-2];

endmodule

// File: rtl/rev_array_mult.sv
module rev_array_mult
  import rev_mult_pkg::*;
#(
  parameter int unsigned OPW = 4
) (
  input  logic [OPW-1:0]                  opa,
  input  logic [OPW-1:0]                  opb,
  output logic [2*OPW-1:0]                prod,
  output logic [garbage_width(OPW)-1:0]   garbage
);

  localparam int unsigned NPP = OPW * OPW;
  localparam int unsigned NHA = ha_count(OPW);
  localparam int unsigned NFA = fa_count(OPW);

  // named stage boundaries, brought out for the checker
  logic [NPP-1:0]   pp_terms;
  logic [OPW-1:0]   gb_pass;
  logic [NPP-1:0]   gb_xor;
  logic [NHA-1:0]   gb_ha;
  logic [2*NFA-1:0] gb_fa;

  rv_ppgen #(.N(OPW)) u_pp (
    .a(opa),
    .b(opb),
    .pp(pp_terms),
    .gb_pass(gb_pass),
    .gb_xor(gb_xor)
  );

  rv_csa_array #(.N(OPW)) u_add (
    .pp(pp_terms),
    .prod(prod),
    .gb_ha(gb_ha),
    .gb_fa(gb_fa)
  );

  assign garbage = {gb_fa, gb_ha, gb_xor, gb_pass};

endmodule

// File: rtl/rev_array_mult_chk.sv
module rev_array_mult_chk #(
  parameter int unsigned OPW = 4
) (
  input logic [OPW-1:0]     opa,
  input logic [OPW-1:0]     opb,
  input logic [2*OPW-1:0]   prod,
  input logic [OPW-1:0]     gb_pass,
  input logic [OPW*OPW-1:0] gb_xor
);

  localparam int unsigned PW = 2 * OPW;

  logic [PW-1:0] ref_prod;
  assign ref_prod = PW'(opa) * PW'(opb);

  always_comb begin
    AST_PRODUCT_EXACT: assert (prod == ref_prod) else $error("product mismatch"); // R1
    if (opa == '0 || opb == '0) begin
      AST_ZERO_OPERAND: assert (prod == '0) else $error("zero operand"); // R2
    end
    if (&opa && &opb) begin
      AST_FULL_SCALE: assert (prod == {{(OPW-1){1'b1}}, {OPW{1'b0}}, 1'b1}) else $error("full scale"); // R3
    end
    AST_ROW_PASS: assert (gb_pass == opb) else $error("row pass"); // R6
    for (int i = 0; i < OPW; i++) begin
      for (int j = 0; j < OPW; j++) begin
        AST_GRID_XOR: assert (gb_xor[i*OPW+j] == (opa[j] ^ opb[i])) else $error("grid xor"); // R7
      end
    end
  end

endmodule

module rv_peres_chk (
  input logic x,
  input logic y,
  input logic z,
  input logic r
);

  always_comb begin
    if (!z) begin
      AST_PERES_AND: assert (r == (x & y)) else $error("peres and"); // R4
    end
  end

endmodule

module rv_fa_chk (
  input logic x,
  input logic y,
  input logic z,
  input logic w,
  input logic p,
  input logic s,
  input logic co
);

  always_comb begin
    AST_FA_PASS: assert (p == x) else $error("fa pass"); // R5
    AST_FA_SUM: assert (s == ^{x, y, z}) else $error("fa sum"); // R5
    if (!w) begin
      AST_FA_MAJORITY: assert (co == ((x & y) | (x & z) | (y & z))) else $error("fa carry"); // R5
    end
  end

endmodule

bind rev_array_mult rev_array_mult_chk #(.OPW(OPW)) u_chk (
  .opa(opa), .opb(opb), .prod(prod), .gb_pass(gb_pass), .gb_xor(gb_xor)
);

bind rv_peres rv_peres_chk u_pchk (.x(x), .y(y), .z(z), .r(r));

bind rv_peres_fa rv_fa_chk u_fchk (
  .x(x), .y(y), .z(z), .w(w), .p(p), .s(s), .co(co)
);

// File: tb/rev_array_mult_tb.sv
`timescale 1ns/1ps
module rev_array_mult_tb;

  localparam int unsigned OPW = 4;
  localparam int unsigned PW  = 2 * OPW;
  localparam int unsigned GBW = OPW*OPW + 2*OPW + 2*OPW*(OPW-2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [OPW-1:0] opa = '0;
  logic [OPW-1:0] opb = '0;
  logic [PW-1:0]  prod;
  logic [GBW-1:0] garbage;

  rev_array_mult #(.OPW(OPW)) u_dut (
    .opa(opa), .opb(opb), .prod(prod), .garbage(garbage)
  );

  // standalone leaf cells for exhaustive mapping checks
  logic tx = 1'b0, ty = 1'b0, tz = 1'b0;
  logic tp, tq, tr;
  rv_peres u_cell_p (.x(tx), .y(ty), .z(tz), .p(tp), .q(tq), .r(tr));

  logic fx = 1'b0, fy = 1'b0, fz = 1'b0, fw = 1'b0;
  logic fp, fq, fs, fco;
  rv_peres_fa u_cell_f (.x(fx), .y(fy), .z(fz), .w(fw), .p(fp), .q(fq), .s(fs), .co(fco));

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [OPW-1:0]     a;
    logic [OPW-1:0]     b;
    logic [PW-1:0]      prod;
    logic [OPW*OPW-1:0] xr;
    string              req;
  } item_t;

  item_t sbq[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bench model: shift-and-add product, per-cell xor lines
  task automatic drive(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    item_t it;
    logic [PW-1:0] acc;
    acc = '0;
    for (int i = 0; i < OPW; i++)
      if (b[i]) acc = acc + (PW'(a) << i);
    it.a = a;
    it.b = b;
    it.prod = acc;
    for (int i = 0; i < OPW; i++)
      for (int j = 0; j < OPW; j++)
        it.xr[i*OPW+j] = a[j] ^ b[i];
    if (a == 0 || b == 0)          it.req = "R2";
    else if (&a && &b)             it.req = "R3";
    else                           it.req = "R1";
    @(posedge clk);
    opa = a;
    opb = b;
    sbq.push_back(it);
  endtask

  // monitor: one item per cycle, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n && sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check(prod == it.prod, it.req, "product", 64'(prod), 64'(it.prod));
      check(garbage[OPW-1:0] == it.b, "R6", "row pass lines",
            64'(garbage[OPW-1:0]), 64'(it.b));
      check(garbage[OPW+OPW*OPW-1:OPW] == it.xr, "R7", "grid xor lines",
            64'(garbage[OPW+OPW*OPW-1:OPW]), 64'(it.xr));
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0]  seen_p;
    logic [15:0] seen_f;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(prod == '0, "R2", "reset-state product, zero operands", 64'(prod), 64'h0);
    rst_n = 1'b1;

    // R1 exhaustive sweep, multiplier outer loop
    for (int bi = 0; bi < (1 << OPW); bi++)
      for (int ai = 0; ai < (1 << OPW); ai++)
        drive(OPW'(ai), OPW'(bi));
    // R3 full scale and R2 zero corners, repeated as directed items
    drive('1, '1);
    drive('0, '1);
    drive('1, '0);
    // walking one against all ones (R1)
    for (int k = 0; k < OPW; k++) drive(OPW'(1 << k), '1);
    repeat (3) @(posedge clk);

    // R4 Peres cell: all 8 patterns, distinct outputs
    seen_p = '0;
    for (int v = 0; v < 8; v++) begin
      logic [2:0] exp_o;
      logic [2:0] got;
      @(posedge clk);
      {tx, ty, tz} = 3'(v);
      @(negedge clk);
      exp_o = {(tx & ty) ^ tz, tx ^ ty, tx};
      got   = {tr, tq, tp};
      check(got == exp_o, "R4", "peres mapping", 64'(got), 64'(exp_o));
      check(!seen_p[got], "R4", "peres output reused", 64'(got), 64'(v));
      seen_p[got] = 1'b1;
    end

    // R5 full-adder cell: all 16 patterns, distinct outputs
    seen_f = '0;
    for (int v = 0; v < 16; v++) begin
      logic [3:0] exp_o;
      logic [3:0] got;
      @(posedge clk);
      {fx, fy, fz, fw} = 4'(v);
      @(negedge clk);
      exp_o = {((fx ^ fy) & fz) ^ (fx & fy) ^ fw, fx ^ fy ^ fz, fx ^ fy, fx};
      got   = {fco, fs, fq, fp};
      check(got == exp_o, "R5", "full-adder mapping", 64'(got), 64'(exp_o));
      check(!seen_f[got], "R5", "full-adder output reused", 64'(got), 64'(v));
      seen_f[got] = 1'b1;
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule